// File: doc/BRIEF.md
# Windowed Raster Frame Mover

This block links a raster video stream to one memory port. The video side is paced by two strobes: a frame-valid level that spans a whole frame and a line-valid level that is high for each pixel of a line. The host programs a rectangular window through a small write-only register port. The window is set by a column start, a row start, a width and a height. The host also sets a memory base address and a direction. It then arms one transfer.

In receive direction, every pixel inside the window is written to memory at consecutive addresses, starting from the base address, in raster order. In transmit direction, the same window pixels are read from memory at the same consecutive addresses. Each word that comes back is driven out with a valid strobe one cycle later. Each completed frame gives a single-cycle done pulse. Which memory bank or banks see the port, including fan-out of received data to several banks, is decided outside this block.

Top module: `roi_stream_port`

## Requirements
- R1: After reset, frame_done, xfer_armed, mem_wr_en, mem_rd_en and tx_valid are all low.
- R2: A host write with host_sel=5 and host_wdata[0]=1 arms the block while it is idle, and xfer_armed is high from the next cycle. The transfer begins only at a rising edge of vid_fv seen after the arm. A frame whose vid_fv was already high at arm time produces no memory access and no done pulse.
- R3: Pixel column counts the vid_lv-high cycles of a line from 0. Pixel row counts the completed lines since vid_fv rose, from 0. A pixel is transferred exactly when xs <= col < xs+width and ys <= row < ys+height. The registers are selected by host_sel: 0 column start xs, 1 row start ys, 2 width, 3 height, 4 base address.
- R4: The first transferred pixel uses the base address, and each later one uses the previous address plus one.
- R5: host_wdata[1] of the arming write picks the direction, with 1 meaning transmit. In transmit, mem_rd_en marks the window pixels and mem_wr_en stays low. tx_valid is high in the cycle after each read, and tx_data is the word returned by memory. In receive, mem_wr_en marks the window pixels with mem_wdata equal to vid_din, and mem_rd_en stays low.
- R6: The cycle after vid_fv falls during an active transfer, frame_done is high for exactly one cycle and xfer_armed is low.
- R7: Register writes and further arming writes made while armed or running do not change the transfer in progress. New register values take effect at the next arm.
- R8: A zero width or zero height gives no memory access, but the frame still ends with a done pulse.
- R9: A window that extends past the last column or last row of the frame transfers only the pixels that exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select (0..5) |
| host_wdata | input | 16 | Host write data |
| vid_fv | input | 1 | Frame-valid strobe |
| vid_lv | input | 1 | Line-valid strobe, one pixel per high cycle |
| vid_din | input | 8 | Incoming pixel data |
| mem_addr | output | 12 | Memory address |
| mem_wr_en | output | 1 | Memory write enable (receive) |
| mem_wdata | output | 8 | Memory write data |
| mem_rd_en | output | 1 | Memory read enable (transmit) |
| mem_rdata | input | 8 | Memory read data, valid one cycle after mem_rd_en |
| tx_valid | output | 1 | Transmit pixel valid |
| tx_data | output | 8 | Transmit pixel data |
| frame_done | output | 1 | One-cycle frame completion pulse |
| xfer_armed | output | 1 | Armed or transferring |

## Verification
The hardest state to reach is an arm that lands while a frame is already in flight. The block must then let that whole frame pass, including its falling edge, without a single access or a done pulse. The bench raises vid_fv first, arms in the middle of the frame, and checks that the frame is ignored before it runs the next frame. A second hard case is a register rewrite plus a conflicting re-arm issued between the arm and the frame start. The bench programs that sequence and checks the addresses and the direction that actually appear at the memory port.

// File: rtl/roi_pkg.sv
package roi_pkg;
    localparam int unsigned PIX_W   = 8;
    localparam int unsigned COORD_W = 12;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned HOST_W  = 16;
    localparam int unsigned SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_XS   = 3'd0,
        SEL_YS   = 3'd1,
        SEL_WID  = 3'd2,
        SEL_HGT  = 3'd3,
        SEL_BASE = 3'd4,
        SEL_CTRL = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic [COORD_W-1:0] xs;
        logic [COORD_W-1:0] ys;
        logic [COORD_W-1:0] wid;
        logic [COORD_W-1:0] hgt;
        logic [ADDR_W-1:0]  base;
        logic               tx;
    } roi_cfg_t;

    function automatic logic in_span(input logic [COORD_W-1:0] pos,
                                     input logic [COORD_W-1:0] start,
                                     input logic [COORD_W-1:0] len);
        logic [COORD_W-1:0] off;
        off = pos - start;
        return (pos >= start) && (off < len);
    endfunction
endpackage

// File: rtl/roi_raster.sv
module roi_raster
    import roi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fv,
    input  logic               lv,
    output logic [COORD_W-1:0] col,
    output logic [COORD_W-1:0] row,
    output logic               pix,
    output logic               sof,
    output logic               eof
);
    logic fv_q, lv_q;
    logic [COORD_W-1:0] col_q, row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fv_q  <= 1'b0;
            lv_q  <= 1'b0;
            col_q <= '0;
            row_q <= '0;
        end else begin
            fv_q  <= fv;
            lv_q  <= lv & fv;
            col_q <= (lv && fv) ? col_q + 1'b1 : '0;
            if (!fv)
                row_q <= '0;
            else if (lv_q && !lv)
                row_q <= row_q + 1'b1;
        end
    end

    assign col = col_q;
    assign row = row_q;
    assign pix = fv & lv;
    assign sof = fv & ~fv_q;
    assign eof = fv_q & ~fv;
endmodule

// File: rtl/roi_ctrl.sv
module roi_ctrl
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              sof,
    input  logic              eof,
    output roi_cfg_t          cfg,
    output logic              running,
    output logic              in_frame,
    output logic              armed,
    output logic              done
);
    xfer_state_e state_q;
    roi_cfg_t    shadow_q, act_q;
    logic        done_q;
    logic        arm_req;
    logic        unused_hi;

    assign unused_hi = ^host_wdata[HOST_W-1:COORD_W];
    assign arm_req = host_we && (host_sel == SEL_CTRL) && host_wdata[0]
                     && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            shadow_q <= '0;
            act_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (host_we) begin
                case (host_sel)
                    SEL_XS:   shadow_q.xs   <= host_wdata[COORD_W-1:0];
                    SEL_YS:   shadow_q.ys   <= host_wdata[COORD_W-1:0];
                    SEL_WID:  shadow_q.wid  <= host_wdata[COORD_W-1:0];
                    SEL_HGT:  shadow_q.hgt  <= host_wdata[COORD_W-1:0];
                    SEL_BASE: shadow_q.base <= host_wdata[ADDR_W-1:0];
                    default:  ;
                endcase
            end
            case (state_q)
                ST_IDLE: if (arm_req) begin
                    state_q  <= ST_WAIT;
                    act_q    <= shadow_q;
                    act_q.tx <= host_wdata[1];
                end
                ST_WAIT: if (sof) state_q <= ST_RUN;
                ST_RUN:  if (eof) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg      = act_q;
    assign running  = (state_q == ST_RUN);
    assign in_frame = running || ((state_q == ST_WAIT) && sof);
    assign armed    = (state_q != ST_IDLE);
    assign done     = done_q;

    // R6: completion is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: the pulse coincides with the block being disarmed
    p_done_disarms_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !armed);
    // R2: a transfer only starts off a frame-start strobe
    p_run_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(sof));
    // R7: the working configuration is frozen while armed
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        armed |=> $stable(cfg));
endmodule

// File: rtl/roi_xfer.sv
module roi_xfer
    import roi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  roi_cfg_t           cfg,
    input  logic               running,
    input  logic               in_frame,
    input  logic               pix,
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    input  logic [PIX_W-1:0]   din,
    input  logic [PIX_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_wr_en,
    output logic [PIX_W-1:0]   mem_wdata,
    output logic               mem_rd_en,
    output logic               tx_valid,
    output logic [PIX_W-1:0]   tx_data
);
    logic              hit;
    logic [ADDR_W-1:0] addr_q, cur_addr;
    logic              txv_q;

    assign hit = in_frame && pix && in_span(col, cfg.xs, cfg.wid)
                 && in_span(row, cfg.ys, cfg.hgt);
    assign cur_addr = running ? addr_q : cfg.base;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            txv_q  <= 1'b0;
        end else begin
            addr_q <= hit ? cur_addr + 1'b1 : cur_addr;
            txv_q  <= hit && cfg.tx;
        end
    end

    assign mem_addr  = cur_addr;
    assign mem_wr_en = hit && !cfg.tx;
    assign mem_rd_en = hit && cfg.tx;
    assign mem_wdata = din;
    assign tx_valid  = txv_q;
    assign tx_data   = mem_rdata;

    // R3: no memory access outside an active frame
    p_no_stray_access_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en || mem_rd_en) |-> in_frame);
    // R5: one direction at a time
    p_dir_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_en && mem_rd_en));
    // R5: each read yields a valid strobe one cycle later
    p_valid_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> tx_valid);
    // R4: consecutive addresses
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en || mem_rd_en) |=> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/roi_stream_port.sv
module roi_stream_port
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              vid_fv,
    input  logic              vid_lv,
    input  logic [PIX_W-1:0]  vid_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_en,
    output logic [PIX_W-1:0]  mem_wdata,
    output logic              mem_rd_en,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              tx_valid,
    output logic [PIX_W-1:0]  tx_data,
    output logic              frame_done,
    output logic              xfer_armed
);
    logic [COORD_W-1:0] col, row;
    logic               pix, sof, eof;
    roi_cfg_t           cfg;
    logic               running, in_frame;

    roi_raster u_raster (
        .clk(clk), .rst(rst), .fv(vid_fv), .lv(vid_lv),
        .col(col), .row(row), .pix(pix), .sof(sof), .eof(eof)
    );

    roi_ctrl u_ctrl (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .sof(sof), .eof(eof), .cfg(cfg),
        .running(running), .in_frame(in_frame), .armed(xfer_armed),
        .done(frame_done)
    );

    roi_xfer u_xfer (
        .clk(clk), .rst(rst), .cfg(cfg), .running(running),
        .in_frame(in_frame), .pix(pix), .col(col), .row(row),
        .din(vid_din), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );
endmodule

// File: tb/test_roi_stream_port.sv
module test_roi_stream_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [15:0] host_wdata = '0;
    logic        vid_fv = 1'b0, vid_lv = 1'b0;
    logic [7:0]  vid_din = '0;
    logic [11:0] mem_addr;
    logic        mem_wr_en, mem_rd_en, tx_valid, frame_done, xfer_armed;
    logic [7:0]  mem_wdata, tx_data;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  bmem [0:4095];

    int checks = 0, fails = 0;
    int frame_err, frame_hits, done_cnt;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    roi_stream_port i_roi_stream_port (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .vid_fv(vid_fv), .vid_lv(vid_lv),
        .vid_din(vid_din), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .frame_done(frame_done),
        .xfer_armed(xfer_armed)
    );

    always @(posedge clk) begin
        if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= bmem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hwrite(input int sel, input int val);
        @(negedge clk);
        host_we = 1'b1; host_sel = 3'(sel); host_wdata = 16'(val);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic program_win(input int xs, ys, w, h, base);
        hwrite(0, xs); hwrite(1, ys); hwrite(2, w); hwrite(3, h); hwrite(4, base);
    endtask

    function automatic bit inwin(input int p, s, l);
        return (p >= s) && (p < s + l);
    endfunction

    // One cycle: drive at negedge, sample 2 ns later, check expected access
    // and the transmit strobe owed by the previous cycle.
    task automatic drive_frame(input int nl, np, input bit act,
                               input int xs, ys, w, h, base, input bit tx);
        int  cnt = 0;
        bit  prev_hit = 1'b0;
        int  prev_addr = 0;
        int  total = 2 + nl * (np + 2) + 4;
        frame_err = 0; frame_hits = 0; done_cnt = 0;
        for (int c = 0; c < total; c++) begin
            int  r, k;
            bit  fv, lv, hit;
            int  col, row;
            fv = (c < 2 + nl * (np + 2));
            lv = 1'b0; col = 0; row = 0;
            if (fv && c >= 2) begin
                r = (c - 2) / (np + 2); k = (c - 2) % (np + 2);
                lv = (k < np); col = k; row = r;
            end
            @(negedge clk);
            vid_fv = fv; vid_lv = lv;
            vid_din = 8'((row * 37 + col * 5 + 11) & 255);
            #2;
            hit = act && lv && inwin(col, xs, w) && inwin(row, ys, h);
            if (tx) begin
                if (mem_rd_en !== hit || mem_wr_en !== 1'b0) frame_err++;
                if (hit && mem_addr !== 12'(base + cnt)) frame_err++;
            end else begin
                if (mem_wr_en !== hit || mem_rd_en !== 1'b0) frame_err++;
                if (hit && (mem_addr !== 12'(base + cnt) || mem_wdata !== vid_din)) frame_err++;
            end
            if (tx_valid !== prev_hit) frame_err++;
            if (prev_hit && tx_data !== bmem[prev_addr]) frame_err++;
            if (frame_done) done_cnt++;
            prev_hit = hit && tx;
            prev_addr = (base + cnt) % 4096;
            if (hit) begin cnt++; frame_hits++; end
        end
    endtask

    // table: xs, ys, w, h, base, tx, lines, pixels-per-line, expected count
    localparam int NV = 6;
    localparam int T_XS [NV] = '{2, 0, 1, 1, 5, 0};
    localparam int T_YS [NV] = '{1, 0, 2, 0, 2, 0};
    localparam int T_W  [NV] = '{3, 8, 4, 0, 10, 1};
    localparam int T_H  [NV] = '{2, 4, 2, 3, 9, 1};
    localparam int T_B  [NV] = '{100, 0, 40, 200, 300, 4095};
    localparam int T_TX [NV] = '{0, 0, 1, 0, 0, 1};
    localparam int T_NL [NV] = '{4, 4, 5, 3, 4, 2};
    localparam int T_NP [NV] = '{8, 8, 6, 5, 8, 3};
    localparam int T_EX [NV] = '{6, 32, 8, 0, 6, 1};

    initial begin
        for (int i = 0; i < 4096; i++) bmem[i] = 8'((i * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check(!frame_done && !xfer_armed && !mem_wr_en && !mem_rd_en && !tx_valid,
              "R1 reset outputs", int'({frame_done, xfer_armed, mem_wr_en, mem_rd_en, tx_valid}), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #2;
        check(!xfer_armed && !frame_done, "R1 idle after reset", int'(xfer_armed), 0);

        for (int v = 0; v < NV; v++) begin
            program_win(T_XS[v], T_YS[v], T_W[v], T_H[v], T_B[v]);
            hwrite(5, 1 + 2 * T_TX[v]);
            #2;
            check(xfer_armed === 1'b1, "R2 armed after control write", int'(xfer_armed), 1);
            drive_frame(T_NL[v], T_NP[v], 1'b1, T_XS[v], T_YS[v], T_W[v], T_H[v], T_B[v], T_TX[v] != 0);
            // vector 0/1 R3 R4, vector 2/5 R5, vector 3 R8, vector 4 R9
            check(frame_err == 0, v == 3 ? "R8 zero-size access pattern" :
                  v == 4 ? "R9 clipped window access pattern" :
                  (T_TX[v] != 0) ? "R5 transmit reads and strobes" : "R3 R4 receive writes",
                  frame_err, 0);
            check(frame_hits == T_EX[v], "R3 transferred pixel count", frame_hits, T_EX[v]);
            check(done_cnt == 1, "R6 one done pulse per frame", done_cnt, 1);
            check(xfer_armed === 1'b0, "R6 disarmed after done", int'(xfer_armed), 0);
        end

        // R2: arm while a frame is already running -> frame ignored
        program_win(0, 0, 8, 8, 500);
        @(negedge clk); vid_fv = 1'b1;
        hwrite(5, 1);
        drive_frame(3, 6, 1'b0, 0, 0, 8, 8, 500, 1'b0);
        check(frame_err == 0 && frame_hits == 0, "R2 in-flight frame ignored", frame_err, 0);
        check(done_cnt == 0, "R2 no done for in-flight frame", done_cnt, 0);
        check(xfer_armed === 1'b1, "R2 still armed for next frame", int'(xfer_armed), 1);
        drive_frame(3, 6, 1'b1, 0, 0, 8, 8, 500, 1'b0);
        check(frame_err == 0 && frame_hits == 18, "R2 next frame transferred", frame_hits, 18);

        // R7: arm receive window, then rewrite registers and re-arm as transmit
        program_win(1, 1, 2, 2, 700);
        hwrite(5, 1);
        program_win(0, 0, 6, 3, 900);
        hwrite(5, 3);
        drive_frame(3, 6, 1'b1, 1, 1, 2, 2, 700, 1'b0);
        check(frame_err == 0 && frame_hits == 4, "R7 old settings and direction kept", frame_err, 0);
        check(done_cnt == 1, "R7 done once", done_cnt, 1);
        // R7: new settings apply at next arm
        hwrite(5, 1);
        drive_frame(3, 6, 1'b1, 0, 0, 6, 3, 900, 1'b0);
        check(frame_err == 0 && frame_hits == 18, "R7 new settings at next arm", frame_hits, 18);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule